// File: doc/BRIEF.md
# Two-Stage Target Address Decoder

This block decides, for every address phase seen by a bus slave, whether the access belongs to it and where it lands. Two banks of base address registers are compared against the address at the same time. The plain bank forwards data untouched. The swapping bank reverses the byte order of each data word in both directions. A hit in either bank leads to a second decode stage. In that stage the address is checked against a set of programmable inclusive windows, one for each chip-select region, and the first matching window picks the region.

When the base compare hits but no window matches, the bus transaction still finishes normally, but the memory access is suppressed. Writes are dropped, and reads return all ones. All decode results are registered and appear one cycle after the address phase. They are then held so that read data returning later is steered by the decode it belongs to. The configuration values (bases, size masks, window bounds) arrive on plain input vectors.

Top module: `tad_top`

## Requirements
- R1: A base entry whose size mask is all zeros never produces a hit, even when its base value equals the address.
- R2: A base entry hits when the address agrees with its base on every bit set in its mask. If an entry of the plain bank and an entry of the swapping bank both hit, the plain bank wins.
- R3: `swap` is 1 only when the decode was won by the swapping bank. Captured write data leaves on `wr_data_out` with byte k moved to byte position (bytes−1−k) when `swap` is 1, and unchanged otherwise.
- R4: Read data given on `rd_in_data` with `rd_in_valid` appears on `rd_out_data` one cycle later, with `rd_out_valid`. It is byte-reversed if the held decode has `swap` = 1 and a region hit, and unchanged if the region hit has `swap` = 0.
- R5: A region matches when low bound ≤ address ≤ high bound (both ends inclusive). A region whose low bound is above its high bound never matches. `region_hit` is 1 only when a base entry also hit.
- R6: When several regions match, `region_idx` carries the lowest-numbered matching region. `region_idx` is 0 whenever `region_hit` is 0.
- R7: A base hit with no region match gives `dec_valid` = 1, `bar_hit` = 1, `region_hit` = 0 and `mem_req` = 0. `mem_req` pulses only for a base hit that also has a region match, and `mem_we` equals `is_write` during such a pulse and is 0 otherwise.
- R8: Read data returned while the held decode has no region match comes out as all ones.
- R9: `dec_valid` and `mem_req` are single-cycle pulses, exactly one cycle after `addr_valid`. A base miss gives `bar_hit` = 0, `swap` = 0 and `region_hit` = 0.
- R10: While `rst` is high, `dec_valid`, `mem_req`, `mem_we`, `rd_out_valid`, `bar_hit`, `swap` and `region_hit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_base | input | 128 | Base values; entries 0..1 are the plain bank, entries 2..3 are the swapping bank; entry i is bits [32i+31:32i] |
| bar_mask | input | 128 | Size masks, same layout; zero disables the entry |
| rgn_lo | input | 128 | Inclusive low bound for each region, region i at [32i+31:32i] |
| rgn_hi | input | 128 | Inclusive high bound for each region |
| addr_valid | input | 1 | Address phase strobe |
| addr | input | 32 | Access address |
| is_write | input | 1 | 1 for a write access |
| wr_data_in | input | 32 | Write data captured with the address phase |
| rd_in_valid | input | 1 | Memory read data strobe |
| rd_in_data | input | 32 | Memory read data |
| dec_valid | output | 1 | Decode result strobe |
| bar_hit | output | 1 | Some base entry hit (held) |
| swap | output | 1 | Swapping bank won (held) |
| region_hit | output | 1 | Second-stage match (held) |
| region_idx | output | 2 | Selected region (held) |
| mem_req | output | 1 | Memory access request pulse |
| mem_we | output | 1 | Memory write enable with `mem_req` |
| wr_data_out | output | 32 | Write data in memory byte order |
| rd_out_valid | output | 1 | Read data strobe toward the bus |
| rd_out_data | output | 32 | Read data in bus byte order |

## Verification
Read data returning for one access and a new address phase can arrive on the same clock edge. The held decode flags are rewritten on that edge, while the returning data must still be steered by the older decode. The bench sets up this overlap on purpose. For example, it returns data for a plain-bank hit in the same cycle that a swapping-bank write is presented, and returns data for a window miss together with a new plain address. The scoreboard computes each read result from the decode that was active before the overlapping address arrived, and it checks the new decode separately when its strobe appears.

// File: rtl/tad_pkg.sv
package tad_pkg;
  localparam int BYTE_W = 8;

  // number of index bits for n items, at least one
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tad_lane_swap.sv
module tad_lane_swap #(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / tad_pkg::BYTE_W;
  localparam int BW    = tad_pkg::BYTE_W;

  logic [DATA_W-1:0] rev;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign rev[k*BW +: BW] = din[(LANES-1-k)*BW +: BW];
    end
  endgenerate

  assign dout = en ? rev : din;
endmodule

// File: rtl/tad_bar_cmp.sv
module tad_bar_cmp #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 4
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ENTRIES*ADDR_W-1:0] base,
  input  logic [ENTRIES*ADDR_W-1:0] mask,
  output logic [ENTRIES-1:0]        hit
);
  genvar i;
  generate
    for (i = 0; i < ENTRIES; i++) begin : g_ent
      logic [ADDR_W-1:0] b, m;
      assign b = base[i*ADDR_W +: ADDR_W];
      assign m = mask[i*ADDR_W +: ADDR_W];
      // an all-zero mask marks the entry as switched off
      assign hit[i] = (|m) && (((addr ^ b) & m) == '0);
    end
  endgenerate
endmodule

// File: rtl/tad_region_cmp.sv
module tad_region_cmp #(
  parameter int ADDR_W  = 32,
  parameter int REGIONS = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [REGIONS*ADDR_W-1:0] lo,
  input  logic [REGIONS*ADDR_W-1:0] hi,
  output logic                      any,
  output logic [IDX_W-1:0]          idx
);
  logic [REGIONS-1:0] match;

  genvar i;
  generate
    for (i = 0; i < REGIONS; i++) begin : g_rgn
      assign match[i] = (addr >= lo[i*ADDR_W +: ADDR_W]) &&
                        (addr <= hi[i*ADDR_W +: ADDR_W]);
    end
  endgenerate

  // scan from the top so the lowest matching number is kept
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int r = REGIONS-1; r >= 0; r--) begin
      if (match[r]) begin
        any = 1'b1;
        idx = IDX_W'(r);
      end
    end
  end
endmodule

// File: rtl/tad_top.sv
module tad_top #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_BAR = 2,
  parameter int NUM_RGN = 4,
  localparam int NB     = 2 * NUM_BAR,
  localparam int IDX_W  = tad_pkg::idx_bits(NUM_RGN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NB*ADDR_W-1:0]      bar_base,
  input  logic [NB*ADDR_W-1:0]      bar_mask,
  input  logic [NUM_RGN*ADDR_W-1:0] rgn_lo,
  input  logic [NUM_RGN*ADDR_W-1:0] rgn_hi,
  input  logic                      addr_valid,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      is_write,
  input  logic [DATA_W-1:0]         wr_data_in,
  input  logic                      rd_in_valid,
  input  logic [DATA_W-1:0]         rd_in_data,
  output logic                      dec_valid,
  output logic                      bar_hit,
  output logic                      swap,
  output logic                      region_hit,
  output logic [IDX_W-1:0]          region_idx,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [DATA_W-1:0]         wr_data_out,
  output logic                      rd_out_valid,
  output logic [DATA_W-1:0]         rd_out_data
);
  logic [NB-1:0]     bhit;
  logic              plain_any, swap_any, bar_any, swap_win;
  logic              rgn_any;
  logic [IDX_W-1:0]  rgn_sel;
  logic [DATA_W-1:0] wr_conv, rd_conv;

  tad_bar_cmp #(.ADDR_W(ADDR_W), .ENTRIES(NB)) u_bar (
    .addr(addr), .base(bar_base), .mask(bar_mask), .hit(bhit)
  );

  tad_region_cmp #(.ADDR_W(ADDR_W), .REGIONS(NUM_RGN), .IDX_W(IDX_W)) u_rgn (
    .addr(addr), .lo(rgn_lo), .hi(rgn_hi), .any(rgn_any), .idx(rgn_sel)
  );

  assign plain_any = |bhit[NUM_BAR-1:0];
  assign swap_any  = |bhit[NB-1:NUM_BAR];
  assign bar_any   = plain_any | swap_any;
  assign swap_win  = swap_any & ~plain_any;

  tad_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .en(swap_win), .din(wr_data_in), .dout(wr_conv)
  );

  tad_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .en(swap), .din(rd_in_data), .dout(rd_conv)
  );

  // decode stage: strobes every cycle, flags held between address phases
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid   <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      bar_hit     <= 1'b0;
      swap        <= 1'b0;
      region_hit  <= 1'b0;
      region_idx  <= '0;
      wr_data_out <= '0;
    end else begin
      dec_valid <= addr_valid;
      mem_req   <= addr_valid & bar_any & rgn_any;
      mem_we    <= addr_valid & bar_any & rgn_any & is_write;
      if (addr_valid) begin
        bar_hit     <= bar_any;
        swap        <= swap_win;
        region_hit  <= bar_any & rgn_any;
        region_idx  <= (bar_any & rgn_any) ? rgn_sel : '0;
        wr_data_out <= wr_conv;
      end
    end
  end

  // return path uses the flags held before this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_out_valid <= 1'b0;
      rd_out_data  <= '0;
    end else begin
      rd_out_valid <= rd_in_valid;
      if (rd_in_valid)
        rd_out_data <= region_hit ? rd_conv : '1;
    end
  end
endmodule

// File: rtl/tad_checker.sv
module tad_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_valid,
  input logic              rd_in_valid,
  input logic              dec_valid,
  input logic              bar_hit,
  input logic              swap,
  input logic              region_hit,
  input logic              mem_req,
  input logic              mem_we,
  input logic              rd_out_valid,
  input logic [DATA_W-1:0] rd_out_data
);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> dec_valid);
  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> !dec_valid && !mem_req);
  assert_swapsrc_R3: assert property (@(posedge clk) disable iff (rst)
    swap |-> bar_hit);
  assert_twostage_R5: assert property (@(posedge clk) disable iff (rst)
    region_hit |-> bar_hit);
  assert_nomem_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> dec_valid && bar_hit && region_hit);
  assert_we_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
  assert_rdlat_R4: assert property (@(posedge clk) disable iff (rst)
    rd_in_valid |=> rd_out_valid);
  assert_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_in_valid && !region_hit) |=> (rd_out_valid && (&rd_out_data)));
endmodule

bind tad_top tad_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr_valid(addr_valid), .rd_in_valid(rd_in_valid),
  .dec_valid(dec_valid), .bar_hit(bar_hit), .swap(swap),
  .region_hit(region_hit), .mem_req(mem_req), .mem_we(mem_we),
  .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data)
);

// File: tb/sim_tad_top.sv
module sim_tad_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  localparam logic [31:0] B0 = 32'h1000_0000, M0 = 32'hF000_0000;
  localparam logic [31:0] B1 = 32'h2000_0000, M1 = 32'h0000_0000;
  localparam logic [31:0] B2 = 32'h8000_0000, M2 = 32'hE000_0000;
  localparam logic [31:0] B3 = 32'h1000_0000, M3 = 32'hF000_0000;
  localparam logic [31:0] L0 = 32'h1000_0000, H0 = 32'h1000_0FFF;
  localparam logic [31:0] L1 = 32'h1000_0800, H1 = 32'h1000_1FFF;
  localparam logic [31:0] L2 = 32'h9000_0000, H2 = 32'h9000_00FF;
  localparam logic [31:0] L3 = 32'h9000_1000, H3 = 32'h9000_0F00;

  logic [127:0] bar_base, bar_mask, rgn_lo, rgn_hi;
  assign bar_base = {B3, B2, B1, B0};
  assign bar_mask = {M3, M2, M1, M0};
  assign rgn_lo   = {L3, L2, L1, L0};
  assign rgn_hi   = {H3, H2, H1, H0};

  logic        addr_valid = 0, is_write = 0, rd_in_valid = 0;
  logic [31:0] addr = 0, wr_data_in = 0, rd_in_data = 0;
  logic        dec_valid, bar_hit, swap, region_hit, mem_req, mem_we, rd_out_valid;
  logic [1:0]  region_idx;
  logic [31:0] wr_data_out, rd_out_data;

  tad_top u0 (
    .clk(clk), .rst(rst), .bar_base(bar_base), .bar_mask(bar_mask),
    .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .addr_valid(addr_valid), .addr(addr),
    .is_write(is_write), .wr_data_in(wr_data_in), .rd_in_valid(rd_in_valid),
    .rd_in_data(rd_in_data), .dec_valid(dec_valid), .bar_hit(bar_hit),
    .swap(swap), .region_hit(region_hit), .region_idx(region_idx),
    .mem_req(mem_req), .mem_we(mem_we), .wr_data_out(wr_data_out),
    .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data)
  );

  int total = 0, bad = 0;
  logic [38:0] dq[$];
  string       dtag[$];
  logic [31:0] rq[$];
  string       rtag[$];
  logic        cur_rh = 0, cur_sw = 0;

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic bhit(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] m);
    return (m != 0) && ((a & m) == (b & m));
  endfunction

  // model from the requirements: returns {bh,sw,rh,idx,req,we,wdata}
  function automatic logic [38:0] model(input logic [31:0] a, input logic we,
                                        input logic [31:0] wd);
    logic p, s, bh, sw, rh;
    logic [1:0] ix;
    logic [31:0] lo[4], hi[4];
    lo = '{L0, L1, L2, L3};
    hi = '{H0, H1, H2, H3};
    p  = bhit(a, B0, M0) || bhit(a, B1, M1);
    s  = bhit(a, B2, M2) || bhit(a, B3, M3);
    bh = p || s;
    sw = s && !p;
    rh = 0; ix = 0;
    for (int i = 0; i < 4; i++)
      if (!rh && bh && a >= lo[i] && a <= hi[i]) begin rh = 1; ix = 2'(i); end
    return {bh, sw, rh, ix, rh, rh & we, sw ? rev(wd) : wd};
  endfunction

  task automatic check(input string tag, input logic [38:0] act,
                       input logic [38:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: presents one cycle of stimulus and queues what should follow
  task automatic step(input bit da, input logic [31:0] a, input bit we,
                      input logic [31:0] wd, input bit dr,
                      input logic [31:0] rd, input string tag);
    logic [38:0] e;
    @(negedge clk);
    if (dr) begin
      rq.push_back(!cur_rh ? 32'hFFFF_FFFF : (cur_sw ? rev(rd) : rd));
      rtag.push_back(tag);
    end
    if (da) begin
      e = model(a, we, wd);
      dq.push_back(e);
      dtag.push_back(tag);
      cur_rh = e[36];
      cur_sw = e[37];
    end
    addr_valid  = da;
    addr        = a;
    is_write    = we;
    wr_data_in  = wd;
    rd_in_valid = dr;
    rd_in_data  = rd;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (dec_valid) begin
        if (dq.size() == 0) check("R9 unexpected dec_valid", 39'd1, 39'd0);
        else check(dtag.pop_front(),
                   {bar_hit, swap, region_hit, region_idx, mem_req, mem_we, wr_data_out},
                   dq.pop_front());
      end else if (mem_req) begin
        check("R9 mem_req without dec_valid", 39'd1, 39'd0);
      end
      if (rd_out_valid) begin
        if (rq.size() == 0) check("R4 unexpected rd_out_valid", 39'd1, 39'd0);
        else check(rtag.pop_front(), {7'd0, rd_out_data}, {7'd0, rq.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs",
          {32'd0, dec_valid, mem_req, mem_we, rd_out_valid, bar_hit, swap, region_hit},
          39'd0);
    @(negedge clk); rst = 0;
    step(1, 32'h1000_0010, 0, 0, 0, 0, "R2 R5 plain read hit region0");
    step(1, 32'h9000_0004, 1, 32'hA1B2_C3D4, 1, 32'h0102_0304,
         "R3 R4 swap write with plain read return overlap");
    step(1, 32'h1000_0800, 1, 32'h1122_3344, 0, 0, "R6 overlap picks region0");
    step(1, 32'h1000_0FFF, 0, 0, 0, 0, "R5 high bound inclusive");
    step(1, 32'h1000_1000, 1, 32'hCAFE_F00D, 0, 0, "R5 R6 region1 only");
    step(1, 32'h1000_0000, 0, 0, 0, 0, "R2 plain beats swap, low bound");
    step(1, 32'h1000_2000, 1, 32'hDEAD_BEEF, 0, 0, "R7 write bar hit region miss");
    step(1, 32'h2000_0000, 0, 0, 0, 0, "R1 disabled entry");
    step(1, 32'h9000_0100, 0, 0, 0, 0, "R7 swap hit region miss");
    step(1, 32'h1000_0020, 0, 0, 1, 32'h1234_5678,
         "R8 miss read returns ones with new addr overlap");
    step(1, 32'h9000_0F80, 0, 0, 0, 0, "R5 inverted window never hits");
    step(1, 32'h0FFF_FFFF, 1, 32'h5555_AAAA, 0, 0, "R9 bar miss");
    step(1, 32'h9000_0008, 0, 0, 0, 0, "R3 swap read hit");
    step(0, 0, 0, 0, 1, 32'h5566_7788, "R4 swapped read data");
    step(0, 0, 0, 0, 0, 0, "R9 idle");
    step(0, 0, 0, 0, 0, 0, "R9 idle");
    step(0, 0, 0, 0, 0, 0, "R9 idle");
    check("R9 all results seen", {7'd0, 32'(dq.size() + rq.size())}, 39'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule